// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It walks a forward-mapped page table that lives in ordinary memory and is made of two levels. Pages are 1 KiB. The top 12 address bits select an entry in the outer table. The outer table starts at the address given on the table-base input. That entry points to an inner table, and the next 10 address bits select a 4-byte entry inside it. The inner entry holds the frame base. The low 10 bits pass through unchanged as the page offset.

Each table entry is 32 bits wide. Bit 0 marks the entry as present. Bit 1 marks a leaf page as writable. Bits 31:10 hold the base address of the next table or of the frame, and its low 10 bits are taken as zero.

Before any memory access, the outer index is checked against a table-length input. The walker takes one request at a time and issues two dependent reads on a valid/ready read port. It returns either the physical address or a 2-bit fault code as a one-cycle response pulse. A process switch only needs the base and length inputs to change between requests, because the walker samples both when it accepts a request.

Top module: `pgwalk_top`

## Requirements
- R1: The virtual address is split with bits 31:20 as the outer index, bits 19:10 as the inner index and bits 9:0 as the page offset.
- R2: The first read goes to table base + 4 × outer index. The second read goes to {outer entry[31:10], 10'b0} + 4 × inner index, and it is issued only after the first read's response has arrived.
- R3: A successful walk responds with rsp_fault low and rsp_paddr = {inner entry[31:10], vaddr[9:0]}.
- R4: Table base and length are sampled when a request is accepted. A change during a walk has no effect on it, and the next request uses the new values.
- R5: Entry bit 0 is the present flag. An absent outer entry gives fault code 1 after exactly one read. An absent inner entry gives fault code 2 after two reads.
- R6: A write whose inner entry has bit 1 clear gives fault code 3. Reads of such a page succeed. Bit 1 of the outer entry has no effect.
- R7: An outer index greater than or equal to tbl_len gives fault code 0 without any memory read. This includes tbl_len = 0.
- R8: req_ready is high only while the walker is idle, so one request is in flight at a time. rsp_valid is high for exactly one cycle per request.
- R9: While mem_rd_valid is high and mem_rd_ready is low, the read request and its address stay unchanged.
- R10: After reset is released, req_ready is high and neither mem_rd_valid nor rsp_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Physical base address of the outer table |
| tbl_len | input | 13 | Number of usable outer entries (0 to 4096) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle translation result |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 2 | Fault code: 0 length, 1 outer absent, 2 inner absent, 3 write to read-only |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The assertions rely on three assumptions about the memory port:
- it returns exactly one response per accepted read;
- it never returns a response that was not asked for;
- its response arrives only after the handshake.

The assertions also assume that req_valid is only asserted together with a stable address and write flag while req_ready is high.

The bench's memory model meets these assumptions. It answers every accepted read once, one cycle later, and can hold mem_rd_ready low for a chosen number of cycles. The bench raises req_valid for a single cycle, and only when req_ready is high.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // Default table geometry
  localparam int GEO_VA_W  = 32;
  localparam int GEO_OFF_W = 10;
  localparam int GEO_HI_W  = 12;
  localparam int GEO_LO_W  = 10;
  localparam int GEO_PTE_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_OUT = 3'd1,
    ST_WT_OUT = 3'd2,
    ST_RD_IN  = 3'd3,
    ST_WT_IN  = 3'd4,
    ST_DONE   = 3'd5,
    ST_FAULT  = 3'd6
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_LEN   = 2'd0,
    FLT_OUTER = 2'd1,
    FLT_INNER = 2'd2,
    FLT_PROT  = 2'd3
  } flt_code_t;

endpackage

// File: rtl/pgwalk_rst_sync.sv
module pgwalk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_ni) begin
          if (!arst_ni) sync_q[s] <= 1'b0;
          else          sync_q[s] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_ni) begin
          if (!arst_ni) sync_q[s] <= 1'b0;
          else          sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int HI_W  = 12,
  parameter int LO_W  = 10,
  parameter int PTE_W = 32
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PTE_W-1:0] tbl_base,
  input  logic [PTE_W-1:0] inner_base,
  input  logic [PTE_W-1:0] frame_base,
  output logic [PTE_W-1:0] outer_addr,
  output logic [PTE_W-1:0] inner_addr,
  output logic [PTE_W-1:0] paddr
);
  localparam int ENT_SH = $clog2(PTE_W / 8);

  logic [HI_W-1:0]  hi_idx;
  logic [LO_W-1:0]  lo_idx;
  logic [OFF_W-1:0] pg_off;

  assign hi_idx = vaddr[VA_W-1 -: HI_W];
  assign lo_idx = vaddr[OFF_W +: LO_W];
  assign pg_off = vaddr[OFF_W-1:0];

  // Entry byte offsets are scaled by the entry size
  assign outer_addr = tbl_base   + (PTE_W'(hi_idx) << ENT_SH);
  assign inner_addr = inner_base + (PTE_W'(lo_idx) << ENT_SH);
  assign paddr      = {frame_base[PTE_W-1:OFF_W], pg_off};
endmodule

// File: rtl/pgwalk_pte.sv
module pgwalk_pte
  import pgwalk_pkg::*;
#(
  parameter int PTE_W   = 32,
  parameter int OFF_W   = 10,
  parameter int VLD_BIT = 0,
  parameter int WR_BIT  = 1
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_leaf,
  input  logic             is_write,
  output logic [PTE_W-1:0] base,
  output logic             fault,
  output flt_code_t        code
);
  logic present;
  logic writable;

  assign present  = entry[VLD_BIT];
  assign writable = entry[WR_BIT];
  assign base     = {entry[PTE_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    fault = 1'b0;
    code  = FLT_PROT;
    if (!present) begin
      fault = 1'b1;
      code  = is_leaf ? FLT_INNER : FLT_OUTER;
    end else if (is_leaf && is_write && !writable) begin
      fault = 1'b1;
      code  = FLT_PROT;
    end
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int HI_W  = 12,
  parameter int PTE_W = 32,
  parameter int LEN_W = HI_W + 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic [PTE_W-1:0] tbl_base_i,
  input  logic [LEN_W-1:0] tbl_len_i,
  output logic             req_ready_o,
  output logic             mem_rd_valid_o,
  input  logic             mem_rd_ready_i,
  output logic [PTE_W-1:0] mem_rd_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic             pte_fault_i,
  input  flt_code_t        pte_code_i,
  input  logic [PTE_W-1:0] pte_base_i,
  input  logic [PTE_W-1:0] outer_addr_i,
  input  logic [PTE_W-1:0] inner_addr_i,
  input  logic [PTE_W-1:0] paddr_i,
  output logic             walk_leaf_o,
  output logic             write_o,
  output logic [VA_W-1:0]  vaddr_o,
  output logic [PTE_W-1:0] base_o,
  output logic [PTE_W-1:0] ptr_o,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_code_o,
  output logic [PTE_W-1:0] rsp_paddr_o
);
  walk_state_t      state_q, state_d;
  logic             run_q;
  logic [VA_W-1:0]  vaddr_q;
  logic             write_q;
  logic [PTE_W-1:0] base_q;
  logic [PTE_W-1:0] ptr_q;
  logic [PTE_W-1:0] paddr_q;
  flt_code_t        code_q, code_d;
  logic             accept;
  logic             ld_ptr;
  logic             ld_leaf;
  logic             code_en;
  logic [HI_W-1:0]  req_hi;
  logic             len_bad;

  assign req_ready_o = run_q && (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign req_hi      = req_vaddr_i[VA_W-1 -: HI_W];
  assign len_bad     = (LEN_W'(req_hi) >= tbl_len_i);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    code_en = 1'b0;
    ld_ptr  = 1'b0;
    ld_leaf = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (len_bad) begin
            state_d = ST_FAULT;
            code_d  = FLT_LEN;
            code_en = 1'b1;
          end else begin
            state_d = ST_RD_OUT;
          end
        end
      end
      ST_RD_OUT: if (mem_rd_ready_i) state_d = ST_WT_OUT;
      ST_WT_OUT: begin
        if (mem_rsp_valid_i) begin
          if (pte_fault_i) begin
            state_d = ST_FAULT;
            code_d  = pte_code_i;
            code_en = 1'b1;
          end else begin
            state_d = ST_RD_IN;
            ld_ptr  = 1'b1;
          end
        end
      end
      ST_RD_IN: if (mem_rd_ready_i) state_d = ST_WT_IN;
      ST_WT_IN: begin
        if (mem_rsp_valid_i) begin
          if (pte_fault_i) begin
            state_d = ST_FAULT;
            code_d  = pte_code_i;
            code_en = 1'b1;
          end else begin
            state_d = ST_DONE;
            ld_leaf = 1'b1;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= 1'b1;
    end
  end

  // Datapath registers, explicit enables, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      vaddr_q <= req_vaddr_i;
      write_q <= req_write_i;
      base_q  <= tbl_base_i;
    end
    if (ld_ptr)  ptr_q   <= pte_base_i;
    if (ld_leaf) paddr_q <= paddr_i;
    if (code_en) code_q  <= code_d;
  end

  assign mem_rd_valid_o = (state_q == ST_RD_OUT) || (state_q == ST_RD_IN);
  assign mem_rd_addr_o  = (state_q == ST_RD_IN) ? inner_addr_i : outer_addr_i;
  assign walk_leaf_o    = (state_q == ST_WT_IN);
  assign write_o        = write_q;
  assign vaddr_o        = vaddr_q;
  assign base_o         = base_q;
  assign ptr_o          = ptr_q;
  assign rsp_valid_o    = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o    = (state_q == ST_FAULT);
  assign rsp_code_o     = code_q;
  assign rsp_paddr_o    = paddr_q;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W    = GEO_VA_W,
  parameter int OFF_W   = GEO_OFF_W,
  parameter int HI_W    = GEO_HI_W,
  parameter int LO_W    = GEO_LO_W,
  parameter int PTE_W   = GEO_PTE_W,
  parameter int VLD_BIT = 0,
  parameter int WR_BIT  = 1,
  parameter int SYNC_N  = 2,
  localparam int LEN_W  = HI_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTE_W-1:0] tbl_base,
  input  logic [LEN_W-1:0] tbl_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PTE_W-1:0] mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_code,
  output logic [PTE_W-1:0] rsp_paddr
);
  logic             srst_n;
  logic             walk_leaf;
  logic             walk_write;
  logic [VA_W-1:0]  walk_vaddr;
  logic [PTE_W-1:0] walk_base;
  logic [PTE_W-1:0] walk_ptr;
  logic [PTE_W-1:0] pte_base;
  logic             pte_fault;
  flt_code_t        pte_code;
  logic [PTE_W-1:0] outer_addr;
  logic [PTE_W-1:0] inner_addr;
  logic [PTE_W-1:0] leaf_paddr;

  pgwalk_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk     (clk),
    .arst_ni (rst_n),
    .srst_no (srst_n)
  );

  pgwalk_addr #(
    .VA_W(VA_W), .OFF_W(OFF_W), .HI_W(HI_W), .LO_W(LO_W), .PTE_W(PTE_W)
  ) u_addr (
    .vaddr      (walk_vaddr),
    .tbl_base   (walk_base),
    .inner_base (walk_ptr),
    .frame_base (pte_base),
    .outer_addr (outer_addr),
    .inner_addr (inner_addr),
    .paddr      (leaf_paddr)
  );

  pgwalk_pte #(
    .PTE_W(PTE_W), .OFF_W(OFF_W), .VLD_BIT(VLD_BIT), .WR_BIT(WR_BIT)
  ) u_pte (
    .entry    (mem_rsp_data),
    .is_leaf  (walk_leaf),
    .is_write (walk_write),
    .base     (pte_base),
    .fault    (pte_fault),
    .code     (pte_code)
  );

  pgwalk_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .HI_W(HI_W), .PTE_W(PTE_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk             (clk),
    .rst_ni          (srst_n),
    .req_valid_i     (req_valid),
    .req_vaddr_i     (req_vaddr),
    .req_write_i     (req_write),
    .tbl_base_i      (tbl_base),
    .tbl_len_i       (tbl_len),
    .req_ready_o     (req_ready),
    .mem_rd_valid_o  (mem_rd_valid),
    .mem_rd_ready_i  (mem_rd_ready),
    .mem_rd_addr_o   (mem_rd_addr),
    .mem_rsp_valid_i (mem_rsp_valid),
    .pte_fault_i     (pte_fault),
    .pte_code_i      (pte_code),
    .pte_base_i      (pte_base),
    .outer_addr_i    (outer_addr),
    .inner_addr_i    (inner_addr),
    .paddr_i         (leaf_paddr),
    .walk_leaf_o     (walk_leaf),
    .write_o         (walk_write),
    .vaddr_o         (walk_vaddr),
    .base_o          (walk_base),
    .ptr_o           (walk_ptr),
    .rsp_valid_o     (rsp_valid),
    .rsp_fault_o     (rsp_fault),
    .rsp_code_o      (rsp_code),
    .rsp_paddr_o     (rsp_paddr)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int HI_W  = 12,
  parameter int LO_W  = 10,
  parameter int PTE_W = 32,
  parameter int LEN_W = HI_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTE_W-1:0] tbl_base,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_write,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [PTE_W-1:0] mem_rd_addr,
  input logic             mem_rsp_valid,
  input logic [PTE_W-1:0] mem_rsp_data,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [1:0]       rsp_code,
  input logic [PTE_W-1:0] rsp_paddr
);
  localparam int ENT_SH = $clog2(PTE_W / 8);

  logic             acc;
  logic             rd_hs;
  logic [1:0]       nrd_q;
  logic [VA_W-1:0]  va_c;
  logic [PTE_W-1:0] base_c;
  logic [PTE_W-1:0] ptr_c;
  logic             wr_c;

  assign acc   = req_valid && req_ready;
  assign rd_hs = mem_rd_valid && mem_rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrd_q  <= '0;
      va_c   <= '0;
      base_c <= '0;
      ptr_c  <= '0;
      wr_c   <= 1'b0;
    end else begin
      if (acc) begin
        nrd_q  <= '0;
        va_c   <= req_vaddr;
        base_c <= tbl_base;
        wr_c   <= req_write;
      end else if (rd_hs) begin
        nrd_q <= nrd_q + 2'd1;
      end
      if (mem_rsp_valid && nrd_q == 2'd1)
        ptr_c <= {mem_rsp_data[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !rsp_valid));
  // R8
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  // R2
  outer_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && nrd_q == 2'd0) |->
      (mem_rd_addr == base_c + (PTE_W'(va_c[VA_W-1 -: HI_W]) << ENT_SH)));
  // R2
  inner_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && nrd_q == 2'd1) |->
      (mem_rd_addr == ptr_c + (PTE_W'(va_c[OFF_W +: LO_W]) << ENT_SH)));
  // R7
  len_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && rsp_code == 2'd0) |-> (nrd_q == 2'd0));
  // R5
  outer_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && rsp_code == 2'd1) |-> (nrd_q == 2'd1));
  // R6
  prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && rsp_code == 2'd3) |-> (wr_c && nrd_q == 2'd2));
  // R3
  ok_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |->
      (rsp_paddr[OFF_W-1:0] == va_c[OFF_W-1:0] && nrd_q == 2'd2));
endmodule

bind pgwalk_top pgwalk_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .HI_W(HI_W), .LO_W(LO_W), .PTE_W(PTE_W)
) u_pgwalk_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tbl_base      (tbl_base),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .req_write     (req_write),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_code      (rsp_code),
  .rsp_paddr     (rsp_paddr)
);

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbl_base = 32'h0001_0000;
  logic [12:0] tbl_len = 13'd8;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] mem [logic [31:0]];
  int          hold_cnt = 0;
  int          stall_cfg = 0;
  int          rd_total = 0;
  logic [31:0] addr_log [8];

  localparam logic [31:0] BASE_A = 32'h0001_0000;
  localparam logic [31:0] BASE_B = 32'h0004_0000;

  always #5 clk = ~clk;

  pgwalk_top u_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  assign mem_rd_ready = (hold_cnt >= stall_cfg);

  // Memory model: one response per accepted read, one cycle later
  always @(posedge clk) begin
    hold_cnt      <= (mem_rd_valid && !mem_rd_ready) ? hold_cnt + 1 : 0;
    mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
    if (mem_rd_valid && mem_rd_ready) begin
      mem_rsp_data          <= lookup(mem_rd_addr);
      addr_log[rd_total % 8] <= mem_rd_addr;
      rd_total              <= rd_total + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Runs one walk; optionally swaps base/length right after acceptance
  task automatic walk(input logic [31:0] va, input bit wr, input bit swap,
                      output bit flt, output logic [1:0] code,
                      output logic [31:0] pa, output int nrd, output int first);
    int guard = 0;
    bit busy_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    first     = rd_total;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (swap) begin
      tbl_base = BASE_B;
      tbl_len  = 13'd0;
    end
    while (!rsp_valid && guard < 200) begin
      if (req_ready) busy_ready = 1'b1;
      @(negedge clk);
      guard++;
    end
    flt  = rsp_fault;
    code = rsp_code;
    pa   = rsp_paddr;
    nrd  = rd_total - first;
    chk("R8 ready low during walk", 32'(busy_ready), 32'd0);
    chk("R8 response seen", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk("R8 one-cycle response", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 ready after reset", 32'(req_ready), 32'd1);
    chk("R10 no read after reset", 32'(mem_rd_valid), 32'd0);
    chk("R10 no response after reset", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_read_ok();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    walk({12'd3, 10'd5, 10'h1A4}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R3 read fault flag", 32'(f), 32'd0);
    chk("R3 read paddr", p, 32'h0055_45A4);
    chk("R2 two reads", 32'(n), 32'd2);
    chk("R1 R2 outer read address", addr_log[s % 8], 32'h0001_000C);
    chk("R1 R2 inner read address", addr_log[(s + 1) % 8], 32'h0002_0014);
  endtask

  task automatic t_write_ok();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    // outer entry has bit 1 clear: must not matter
    walk({12'd3, 10'd5, 10'h001}, 1'b1, 1'b0, f, c, p, n, s);
    chk("R6 write to writable page", 32'(f), 32'd0);
    chk("R6 write paddr", p, 32'h0055_4401);
  endtask

  task automatic t_readonly();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    walk({12'd3, 10'd6, 10'h3FF}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R6 read of read-only page", 32'(f), 32'd0);
    chk("R6 read-only paddr", p, 32'h0077_0BFF);
    walk({12'd3, 10'd6, 10'h3FF}, 1'b1, 1'b0, f, c, p, n, s);
    chk("R6 write to read-only faults", 32'(f), 32'd1);
    chk("R6 write-protect code", 32'(c), 32'd3);
  endtask

  task automatic t_outer_abs();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    walk({12'd4, 10'd5, 10'h000}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R5 outer absent faults", 32'(f), 32'd1);
    chk("R5 outer absent code", 32'(c), 32'd1);
    chk("R5 outer absent one read", 32'(n), 32'd1);
  endtask

  task automatic t_inner_abs();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    walk({12'd3, 10'd7, 10'h000}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R5 inner absent faults", 32'(f), 32'd1);
    chk("R5 inner absent code", 32'(c), 32'd2);
    chk("R5 inner absent two reads", 32'(n), 32'd2);
  endtask

  task automatic t_length();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    walk({12'd8, 10'd0, 10'h000}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R7 index equal to length faults", 32'(f), 32'd1);
    chk("R7 length code", 32'(c), 32'd0);
    chk("R7 no memory read", 32'(n), 32'd0);
    walk({12'd7, 10'd0, 10'h010}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R7 last index in range", 32'(f), 32'd0);
    chk("R7 last index paddr", p, 32'h0012_3410);
    tbl_len = 13'd0;
    walk({12'd0, 10'd0, 10'h000}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R7 zero length faults", 32'(f), 32'd1);
    chk("R7 zero length no read", 32'(n), 32'd0);
    tbl_len = 13'd8;
  endtask

  task automatic t_max_index();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    tbl_len = 13'd4096;
    walk(32'hFFFF_FFFF, 1'b1, 1'b0, f, c, p, n, s);
    chk("R1 top indices translate", 32'(f), 32'd0);
    chk("R3 top indices paddr", p, 32'hFFFF_FFFF);
    chk("R2 top outer address", addr_log[s % 8], 32'h0001_3FFC);
    chk("R2 top inner address", addr_log[(s + 1) % 8], 32'h0002_0FFC);
    tbl_len = 13'd8;
  endtask

  task automatic t_base_switch();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    tbl_base = BASE_B;
    walk({12'd3, 10'd5, 10'h1A4}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R4 new base used", p, 32'h00AB_C1A4);
    chk("R4 new base outer address", addr_log[s % 8], 32'h0004_000C);
    tbl_base = BASE_A;
    walk({12'd3, 10'd5, 10'h1A4}, 1'b0, 1'b1, f, c, p, n, s);
    chk("R4 mid-walk change ignored fault", 32'(f), 32'd0);
    chk("R4 mid-walk change ignored paddr", p, 32'h0055_45A4);
    tbl_base = BASE_A;
    tbl_len  = 13'd8;
  endtask

  task automatic t_stall();
    bit f; logic [1:0] c; logic [31:0] p; int n, s;
    stall_cfg = 3;
    walk({12'd3, 10'd5, 10'h2B0}, 1'b0, 1'b0, f, c, p, n, s);
    chk("R9 stalled walk paddr", p, 32'h0055_46B0);
    chk("R9 stalled walk reads", 32'(n), 32'd2);
    chk("R9 stalled inner address", addr_log[(s + 1) % 8], 32'h0002_0014);
    stall_cfg = 0;
  endtask

  initial begin
    mem[32'h0001_000C] = 32'h0002_0001;      // outer 3 -> inner table 0x20000 (bit1 clear)
    mem[32'h0001_0010] = 32'h0003_0000;      // outer 4 absent
    mem[32'h0001_001C] = 32'h0002_0001;      // outer 7
    mem[32'h0001_3FFC] = 32'h0002_0001;      // outer 4095
    mem[32'h0002_0000] = 32'h0012_3401;      // inner 0 read-only
    mem[32'h0002_0014] = 32'h0055_4403;      // inner 5 writable
    mem[32'h0002_0018] = 32'h0077_0801;      // inner 6 read-only
    mem[32'h0002_001C] = 32'h0099_0002;      // inner 7 absent
    mem[32'h0002_0FFC] = 32'hFFFF_FC03;      // inner 1023 writable
    mem[32'h0004_000C] = 32'h0005_0001;      // table B outer 3
    mem[32'h0005_0014] = 32'h00AB_C001;      // table B inner 5
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_read_ok();
    t_write_ok();
    t_readonly();
    t_outer_abs();
    t_inner_abs();
    t_length();
    t_max_index();
    t_base_switch();
    t_stall();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule